// File: doc/BRIEF.md
# Card Sleep/Awake Controller

This block is the device-side controller that moves a managed flash card between its Standby and Sleep states. It watches a decoded command stream: a valid strobe, a 6-bit command index and a 32-bit argument. When it sees the sleep/awake command, it starts the matching transition. During a transition it pulls the DAT0 line low through an open-drain enable. It releases the line after a busy window whose length comes from a configuration timeout field.

While the card sleeps, the controller filters the command stream. Only the reset command and a valid wake-up request get through. Every other command is ignored, and commands that point the wrong way are flagged as errors. A registered output tells the power logic when the core supply may be switched off. A second input reports that the supply is back, and a wake-up is only allowed once it is.

Top module: `cardslp_ctrl`

## Requirements
- R1: After the synchronous reset input, the state output reads Standby (encoding: 0 Standby, 1 entering Sleep, 2 Sleep, 3 leaving Sleep). At the same time the DAT0 drive enable, the supply-off flag, both sticky flags and both response pulses are low.
- R2: Command index 5 with argument bit 15 at 1, received in Standby, is accepted and moves the state to 1. DAT0 is then pulled low for exactly (timeout+1)*4 clock cycles, after which the state becomes 2 in the same cycle the line is released.
- R3: Command index 5 with argument bit 15 at 0, received in Sleep, is accepted only if the supply-good input is high. It then moves the state to 3, pulls DAT0 low for (timeout+1)*4 cycles, and ends in Standby. If the supply-good input is low, the command is ignored and the state stays 2.
- R4: DAT0 is handled as open drain: the block only ever enables a low drive. That enable is high only while the state is 1 or 3.
- R5: In Sleep, any command index other than 0 and 5 is ignored. It causes no state change and no busy.
- R6: Any command other than reset that arrives during a transition is ignored. It does not change the busy length, and it sets a sticky busy-command flag.
- R7: A sleep request in Sleep, or a wake request in Standby, is ignored and sets a sticky illegal-command flag.
- R8: Command index 0 in any state, including mid-transition, moves the state to Standby. It releases DAT0 on the next clock and clears both sticky flags.
- R9: The supply-off flag rises one cycle after Sleep is entered, once DAT0 reads high. It falls on the same clock edge at which a wake transition starts.
- R10: Each command produces exactly one one-cycle pulse, either accept or ignore, in the cycle after it is sampled. A command other than 0 and 5 received in Standby is accepted and leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_vld | input | 1 | Command strobe, one cycle per command |
| cmd_idx | input | 6 | Decoded command index |
| cmd_arg | input | 32 | Command argument; bit 15 selects sleep (1) or wake (0) |
| tmo_code | input | 8 | Transition timeout field; busy lasts (tmo_code+1)*4 cycles |
| vcc_ok | input | 1 | Core supply is at or above its minimum level |
| dat0_in | input | 1 | Sampled level of the DAT0 line |
| dat0_oe | output | 1 | Drive-low enable for DAT0 (busy) |
| card_state | output | 2 | Current state code |
| cmd_acc | output | 1 | Pulse: last command accepted |
| cmd_ign | output | 1 | Pulse: last command ignored |
| vcc_off_ok | output | 1 | Core supply may be removed |
| illegal_err | output | 1 | Sticky: wrong-direction sleep/awake seen |
| busy_cmd_seen | output | 1 | Sticky: command issued while busy |

## Verification
The sleep/awake command is driven with both values of argument bit 15 in both stable states. This separates real transitions from wrong-direction requests that must only raise the error flag. A wake request is sent once with the supply-good input low and once with it high, which shows that the supply gate matters.

Busy windows are measured with two timeout codes, which catches both an off-by-one error and an ignored scaling. One window has a command injected mid-busy, which must not stretch or shorten it. Reset commands are sent from Standby and from inside a transition, which shows that the abort releases DAT0 on the next clock and clears the flags.

// File: rtl/cardslp_pkg.sv
package cardslp_pkg;

  typedef enum logic [1:0] {
    ST_STBY    = 2'd0,
    ST_TO_SLP  = 2'd1,
    ST_SLP     = 2'd2,
    ST_TO_STBY = 2'd3
  } slp_state_e;

  typedef enum logic [2:0] {
    CK_NONE,
    CK_RST,
    CK_SLEEP,
    CK_AWAKE,
    CK_OTHER
  } cmd_kind_e;

endpackage

// File: rtl/cardslp_cmd_dec.sv
module cardslp_cmd_dec
  import cardslp_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int ARG_W   = 32,
  parameter int RST_IDX = 0,
  parameter int SA_IDX  = 5,
  parameter int SEL_BIT = 15
) (
  input  logic             cmd_vld,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic [ARG_W-1:0] cmd_arg,
  output cmd_kind_e        kind
);

  localparam logic [IDX_W-1:0] RST_CODE = IDX_W'(RST_IDX);
  localparam logic [IDX_W-1:0] SA_CODE  = IDX_W'(SA_IDX);

  logic arg_unused;
  assign arg_unused = ^cmd_arg;

  always_comb begin
    kind = CK_NONE;
    if (cmd_vld) begin
      if (cmd_idx == RST_CODE)     kind = CK_RST;
      else if (cmd_idx == SA_CODE) kind = cmd_arg[SEL_BIT] ? CK_SLEEP : CK_AWAKE;
      else                         kind = CK_OTHER;
    end
  end

endmodule

// File: rtl/cardslp_busy_tmr.sv
module cardslp_busy_tmr #(
  parameter int TMO_W    = 8,
  parameter int SCALE_SH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             clear,
  input  logic [TMO_W-1:0] tmo_code,
  output logic             done
);

  localparam int CNT_W = TMO_W + SCALE_SH;
  localparam logic [CNT_W-1:0] LOW_ONES = CNT_W'((1 << SCALE_SH) - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  assign done = act_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (load) begin
      act_q <= 1'b1;
      cnt_q <= {tmo_code, {SCALE_SH{1'b0}}} | LOW_ONES;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2
  tmr_count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q && !clear && !load && cnt_q != '0) |=> (act_q && cnt_q == $past(cnt_q) - 1'b1));

  // R6
  tmr_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!act_q && !load) |=> !act_q);

endmodule

// File: rtl/cardslp_fsm.sv
module cardslp_fsm
  import cardslp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cmd_kind_e  kind,
  input  logic       vcc_ok,
  input  logic       dat0_in,
  input  logic       tmr_done,
  output slp_state_e state_q,
  output logic       tmr_load,
  output logic       tmr_clear,
  output logic       dat0_oe,
  output logic       acc_q,
  output logic       ign_q,
  output logic       ill_q,
  output logic       bsy_q,
  output logic       vcc_off_q
);

  slp_state_e state_n;
  logic acc_n, ign_n, ill_set, bsy_set, flag_clr;
  logic in_xfer;

  assign in_xfer = (state_q == ST_TO_SLP) || (state_q == ST_TO_STBY);

  always_comb begin
    state_n   = state_q;
    tmr_load  = 1'b0;
    tmr_clear = 1'b0;
    acc_n     = 1'b0;
    ign_n     = 1'b0;
    ill_set   = 1'b0;
    bsy_set   = 1'b0;
    flag_clr  = 1'b0;
    if (kind == CK_RST) begin
      state_n   = ST_STBY;
      tmr_clear = 1'b1;
      acc_n     = 1'b1;
      flag_clr  = 1'b1;
    end else begin
      if (kind != CK_NONE) begin
        case (state_q)
          ST_STBY: begin
            if (kind == CK_SLEEP) begin
              state_n  = ST_TO_SLP;
              tmr_load = 1'b1;
              acc_n    = 1'b1;
            end else if (kind == CK_AWAKE) begin
              ign_n   = 1'b1;
              ill_set = 1'b1;
            end else begin
              acc_n = 1'b1;
            end
          end
          ST_SLP: begin
            if (kind == CK_AWAKE && vcc_ok) begin
              state_n  = ST_TO_STBY;
              tmr_load = 1'b1;
              acc_n    = 1'b1;
            end else begin
              ign_n   = 1'b1;
              ill_set = (kind == CK_SLEEP);
            end
          end
          default: begin
            ign_n   = 1'b1;
            bsy_set = 1'b1;
          end
        endcase
      end
      if (in_xfer && tmr_done)
        state_n = (state_q == ST_TO_SLP) ? ST_SLP : ST_STBY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_STBY;
      dat0_oe   <= 1'b0;
      acc_q     <= 1'b0;
      ign_q     <= 1'b0;
      ill_q     <= 1'b0;
      bsy_q     <= 1'b0;
      vcc_off_q <= 1'b0;
    end else begin
      state_q   <= state_n;
      dat0_oe   <= (state_n == ST_TO_SLP) || (state_n == ST_TO_STBY);
      acc_q     <= acc_n;
      ign_q     <= ign_n;
      ill_q     <= !flag_clr && (ill_q || ill_set);
      bsy_q     <= !flag_clr && (bsy_q || bsy_set);
      vcc_off_q <= (state_n == ST_SLP) && dat0_in;
    end
  end

  // R8
  rst_cmd_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == CK_RST) |=> (state_q == ST_STBY && !dat0_oe && !ill_q && !bsy_q));

  // R5
  sleep_filter_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLP && kind == CK_OTHER) |=> (state_q == ST_SLP && !dat0_oe && ign_q));

  // R3
  awake_needs_vcc_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TO_STBY && $past(state_q) == ST_SLP) |-> $past(vcc_ok));

  // R4
  busy_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dat0_oe) |-> (state_q != $past(state_q)));

endmodule

// File: rtl/cardslp_ctrl.sv
module cardslp_ctrl
  import cardslp_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int ARG_W    = 32,
  parameter int TMO_W    = 8,
  parameter int SCALE_SH = 2,
  parameter int SEL_BIT  = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_vld,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic [ARG_W-1:0] cmd_arg,
  input  logic [TMO_W-1:0] tmo_code,
  input  logic             vcc_ok,
  input  logic             dat0_in,
  output logic             dat0_oe,
  output logic [1:0]       card_state,
  output logic             cmd_acc,
  output logic             cmd_ign,
  output logic             vcc_off_ok,
  output logic             illegal_err,
  output logic             busy_cmd_seen
);

  cmd_kind_e  kind;
  slp_state_e state_q;
  logic       tmr_load, tmr_clear, tmr_done;

  cardslp_cmd_dec #(
    .IDX_W  (IDX_W),
    .ARG_W  (ARG_W),
    .SEL_BIT(SEL_BIT)
  ) u_dec (
    .cmd_vld(cmd_vld),
    .cmd_idx(cmd_idx),
    .cmd_arg(cmd_arg),
    .kind   (kind)
  );

  cardslp_busy_tmr #(
    .TMO_W   (TMO_W),
    .SCALE_SH(SCALE_SH)
  ) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .clear   (tmr_clear),
    .tmo_code(tmo_code),
    .done    (tmr_done)
  );

  cardslp_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .kind     (kind),
    .vcc_ok   (vcc_ok),
    .dat0_in  (dat0_in),
    .tmr_done (tmr_done),
    .state_q  (state_q),
    .tmr_load (tmr_load),
    .tmr_clear(tmr_clear),
    .dat0_oe  (dat0_oe),
    .acc_q    (cmd_acc),
    .ign_q    (cmd_ign),
    .ill_q    (illegal_err),
    .bsy_q    (busy_cmd_seen),
    .vcc_off_q(vcc_off_ok)
  );

  assign card_state = state_q;

  // R9
  vcc_off_in_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    vcc_off_ok |-> (card_state == 2'd2 && !dat0_oe));

  // R10
  one_response_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_acc && cmd_ign));

  // R4
  oe_only_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    dat0_oe |-> (card_state == 2'd1 || card_state == 2'd3));

endmodule

// File: tb/cardslp_ctrl_bench.sv
module cardslp_ctrl_bench;

  localparam int ACC = 1;
  localparam int IGN = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_vld = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic [7:0]  tmo_code = 8'd2;
  logic        vcc_ok = 1'b1;
  logic        dat0_in;
  logic        dat0_oe;
  logic [1:0]  card_state;
  logic        cmd_acc, cmd_ign, vcc_off_ok, illegal_err, busy_cmd_seen;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  assign dat0_in = ~dat0_oe;

  cardslp_ctrl u_cardslp_ctrl (
    .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .tmo_code(tmo_code), .vcc_ok(vcc_ok), .dat0_in(dat0_in), .dat0_oe(dat0_oe),
    .card_state(card_state), .cmd_acc(cmd_acc), .cmd_ign(cmd_ign),
    .vcc_off_ok(vcc_off_ok), .illegal_err(illegal_err), .busy_cmd_seen(busy_cmd_seen)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(int idx, bit b15, int kind, string req);
    @(negedge clk);
    cmd_vld = 1'b1;
    cmd_idx = 6'(idx);
    cmd_arg = 32'h5A3C_0000 | (32'(b15) << 15) | 32'h0000_0042;
    exp_q.push_back(kind);
    tag_q.push_back(req);
    @(negedge clk);
    cmd_vld = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (dat0_oe && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && (cmd_acc || cmd_ign)) begin
      if (exp_q.size() == 0) begin
        chk("R10 unexpected response", cmd_acc ? ACC : IGN, 0);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " response"}, (cmd_acc && cmd_ign) ? 3 : (cmd_acc ? ACC : IGN), e);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    chk("R1 state", card_state, 0);
    chk("R1 dat0_oe", dat0_oe, 0);
    chk("R1 vcc_off_ok", vcc_off_ok, 0);
    chk("R1 flags", {illegal_err, busy_cmd_seen, cmd_acc, cmd_ign}, 0);

    // R10 other command in Standby accepted
    issue(17, 1'b0, ACC, "R10");
    chk("R10 state kept", card_state, 0);

    // R7 wake in Standby
    issue(5, 1'b0, IGN, "R7");
    chk("R7 illegal_err", illegal_err, 1);
    chk("R7 state", card_state, 0);
    chk("R7 no busy", dat0_oe, 0);

    // R8 reset clears flag
    issue(0, 1'b0, ACC, "R8");
    chk("R8 flag cleared", illegal_err, 0);

    // R2 sleep, tmo=2 -> 12 cycles
    issue(5, 1'b1, ACC, "R2");
    chk("R2 entering", card_state, 1);
    busy_len(n);
    chk("R2 busy length", n, 12);
    chk("R2 sleep reached", card_state, 2);
    chk("R9 not yet", vcc_off_ok, 0);
    @(negedge clk);
    chk("R9 raised", vcc_off_ok, 1);

    // R5 filter in sleep
    issue(17, 1'b1, IGN, "R5");
    chk("R5 state", card_state, 2);
    chk("R5 no busy", dat0_oe, 0);
    issue(42, 1'b0, IGN, "R5");
    chk("R5 state again", card_state, 2);

    // R7 sleep in sleep
    issue(5, 1'b1, IGN, "R7");
    chk("R7 illegal in sleep", illegal_err, 1);
    chk("R7 sleep kept", card_state, 2);

    // R3 wake without supply
    vcc_ok = 1'b0;
    issue(5, 1'b0, IGN, "R3");
    chk("R3 gated state", card_state, 2);
    chk("R3 gated busy", dat0_oe, 0);

    // R3 wake with supply
    vcc_ok = 1'b1;
    issue(5, 1'b0, ACC, "R3");
    chk("R3 leaving", card_state, 3);
    chk("R9 fell at wake", vcc_off_ok, 0);
    chk("R4 busy during wake", dat0_oe, 1);
    busy_len(n);
    chk("R3 busy length", n, 12);
    chk("R3 standby reached", card_state, 0);

    // R6 command during busy, tmo=0 -> 4 cycles
    tmo_code = 8'd0;
    issue(5, 1'b1, ACC, "R2");
    issue(13, 1'b0, IGN, "R6");
    chk("R6 flag", busy_cmd_seen, 1);
    chk("R6 still entering", card_state, 1);
    busy_len(n);
    chk("R6 remaining busy", n, 2);
    chk("R6 sleep reached", card_state, 2);

    // R8 reset from sleep
    issue(0, 1'b0, ACC, "R8");
    chk("R8 from sleep", card_state, 0);
    chk("R8 flags cleared", {illegal_err, busy_cmd_seen}, 0);

    // R8 reset mid-transition
    tmo_code = 8'd2;
    issue(5, 1'b1, ACC, "R2");
    issue(0, 1'b0, ACC, "R8");
    chk("R8 abort oe", dat0_oe, 0);
    chk("R8 abort state", card_state, 0);
    repeat (14) @(negedge clk);
    chk("R8 stays standby", card_state, 0);

    repeat (2) @(negedge clk);
    chk("R10 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule